// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block drives the two gate-enable outputs of a synchronous buck half bridge, one for the high-side switch and one for the low-side switch. It takes a high-side request and a low-side request and turns them into gate commands that never overlap. The dead time between the two gates is not a fixed delay. Each turn-on waits until the opposite switch is sensed to be off. Three comparator flags report this, and they arrive already synchronized to the clock. One flag says that the low-side gate has fallen below about 1 V. One says that the switch node has fallen below about 2.2 V. The third says that the high-side gate-source voltage has fallen below about 1.2 V.

The switch-node flag may never arrive. The bootstrap capacitor must still be recharged on every cycle, so a secondary timer covers this case. The timer is armed by the high-side gate-source flag. When it expires, the low-side gate turns on whether or not the switch node has fallen. A one-cycle status pulse marks each low-side turn-on that the timer caused. The timeout length is a cycle count (`TIMEOUT_CYC`). It must be set longer than the normal switch-node dead time, for example 25 cycles of a 100 MHz clock for 250 ns.

When no request is active, or when both requests are active at once, both gates are held low and no wait is started. This covers disable, the mid-level shutdown and skip mode upstream.

Top module: `deadtime_gate_seq`

## Requirements
- R1: During and right after a synchronous active-low reset, `hs_gate`, `ls_gate` and `timeout_pulse` are all 0.
- R2: `hs_gate` and `ls_gate` are never 1 in the same cycle.
- R3: When only `hs_req` is active and the high side is not already on, `ls_gate` drops at the next edge and the sequencer waits. `hs_gate` rises at the first later edge at which `ls_off_flag` is sampled high. There is therefore always at least one cycle with both gates low.
- R4: When only `ls_req` is active and the low side is not already on, `hs_gate` drops at the next edge and the sequencer waits. `ls_gate` rises at the first later edge at which `sw_low_flag` is sampled high, unless the timeout of R5 fires earlier.
- R5: While the low-side wait is in progress, sampling `hs_off_flag` high arms a counter. Let E0 be the edge at which the wait is entered, and let Ea (a ≥ 1) be the first later edge at which `hs_off_flag` is sampled high. `ls_gate` then rises no later than edge E(a+TIMEOUT_CYC), whatever `sw_low_flag` does.
- R6: If the switch-node flag and the timer expiry fall on the same edge, the turn-on counts as a switch-node turn-on.
- R7: `timeout_pulse` is 1 for exactly one cycle, the first cycle of `ls_gate` high, and only when the timer rather than `sw_low_flag` caused the turn-on.
- R8: If neither request or both requests are active, both gates are 0 after the next edge and stay 0 regardless of the flags.
- R9: A request that changes during a wait abandons the pending turn-on. The gate that was waiting never rises, and the sequencer follows the new request.
- R10: The timer is cleared whenever the sequencer leaves the low-side wait. A new wait measures its timeout from its own arming edge.
- R11: While a gate is on and its request is held, it stays on whatever the comparator flags do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_req | input | 1 | Request to turn the high-side switch on |
| ls_req | input | 1 | Request to turn the low-side switch on |
| ls_off_flag | input | 1 | Low-side gate below about 1 V (synchronized) |
| sw_low_flag | input | 1 | Switch node below about 2.2 V (synchronized) |
| hs_off_flag | input | 1 | High-side gate-source below about 1.2 V (synchronized) |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| timeout_pulse | output | 1 | One-cycle marker of a timer-forced low-side turn-on |

## Verification
Several properties are checked on every cycle. The two gates are never on together. Each high-side rise is preceded by a sampled low-side-off flag. Each low-side rise is preceded by either the switch-node flag or timer expiry. The timeout pulse appears only with the low-side gate and without the switch-node flag. An idle or conflicting request blanks both gates, and the timer is cleared outside the wait. Other behaviours can only be shown by the bench's scenarios. These are the exact turn-on edge as the arming delay and switch-node delay are swept against each other, the tie between the flag and the timer, abandoning a wait midway, restarting the timer after it was cleared, and holding a gate while the flags toggle.

// File: rtl/gseq_pkg.sv
// Shared types of the dead-time gate sequencer.
package gseq_pkg;
    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_HS_ON   = 3'd1,
        ST_LS_ON   = 3'd2,
        ST_WAIT_GL = 3'd3,
        ST_WAIT_SW = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_HS   = 2'd1,
        CMD_LS   = 2'd2
    } seq_cmd_t;
endpackage

// File: rtl/gseq_req_decode.sv
// Reduces the two request lines to a single command.
// Assumes the requests are already synchronous to clk. When both requests
// are active they conflict, and the result is treated as no request.
module gseq_req_decode
    import gseq_pkg::*;
(
    input  logic     hs_req,
    input  logic     ls_req,
    output seq_cmd_t cmd
);
    // Purpose: pick one command; an idle or conflicting pair gives CMD_NONE.
    always_comb begin
        if (hs_req && !ls_req)      cmd = CMD_HS;
        else if (ls_req && !hs_req) cmd = CMD_LS;
        else                        cmd = CMD_NONE;
    end
endmodule

// File: rtl/gseq_timer.sv
// Secondary low-side timeout. Counts only while run is high, once start
// has been sampled high. Saturates at TIMEOUT_CYC and reports expiry.
// Cleared on any cycle when run is low.
// Assumes TIMEOUT_CYC >= 2.
module gseq_timer #(
    parameter int TIMEOUT_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic start,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(TIMEOUT_CYC);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);
    localparam logic [CW-1:0] CNT_ZERO = '0;

    logic [CW-1:0] cnt;

    // Purpose: arm on start, count up to CNT_MAX, clear outside the wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_ZERO;
        end else if (!run) begin
            cnt <= CNT_ZERO;
        end else if ((cnt != CNT_ZERO || start) && cnt != CNT_MAX) begin
            cnt <= cnt + CNT_ONE;
        end
    end

    assign expired = (cnt == CNT_MAX);

    assert_timer_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == CNT_ZERO));
    assert_timer_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX);
endmodule

// File: rtl/gseq_fsm.sv
// Sequencing state machine. Each turn-on passes through a wait state that
// ends only on the matching turn-off evidence: the low-side-off flag for
// the high side, and the switch-node flag or timer expiry for the low side.
// Also registers the timeout-cause pulse. Assumes the flags are synchronous.
module gseq_fsm
    import gseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_cmd_t   cmd,
    input  logic       ls_off_flag,
    input  logic       sw_low_flag,
    input  logic       expired,
    output seq_state_t state,
    output seq_state_t next_state,
    output logic       timeout_pulse
);
    // Purpose: next-state rule; a changed request always restarts from here.
    always_comb begin
        next_state = state;
        unique case (cmd)
            CMD_HS: begin
                if (state == ST_HS_ON)
                    next_state = ST_HS_ON;
                else if (state == ST_WAIT_GL && ls_off_flag)
                    next_state = ST_HS_ON;
                else
                    next_state = ST_WAIT_GL;
            end
            CMD_LS: begin
                if (state == ST_LS_ON)
                    next_state = ST_LS_ON;
                else if (state == ST_WAIT_SW && (sw_low_flag || expired))
                    next_state = ST_LS_ON;
                else
                    next_state = ST_WAIT_SW;
            end
            default: next_state = ST_OFF;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= next_state;
    end

    // Purpose: flag a low-side turn-on caused by the timer alone.
    always_ff @(posedge clk) begin
        if (!rst_n)
            timeout_pulse <= 1'b0;
        else
            timeout_pulse <= (state == ST_WAIT_SW) && (cmd == CMD_LS)
                             && expired && !sw_low_flag;
    end
endmodule

// File: rtl/gseq_drive.sv
// Gate output registers, loaded from the sequencer's next state, so each
// gate changes on the same edge as the state. Both are cleared in reset.
module gseq_drive
    import gseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t next_state,
    output logic       hs_gate,
    output logic       ls_gate
);
    // Purpose: high-side gate register.
    always_ff @(posedge clk) begin
        if (!rst_n) hs_gate <= 1'b0;
        else        hs_gate <= (next_state == ST_HS_ON);
    end

    // Purpose: low-side gate register.
    always_ff @(posedge clk) begin
        if (!rst_n) ls_gate <= 1'b0;
        else        ls_gate <= (next_state == ST_LS_ON);
    end

    assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));
endmodule

// File: rtl/deadtime_gate_seq.sv
// Adaptive dead-time gate sequencer for a half bridge. Turns a high-side
// request and a low-side request into non-overlapping gate enables. Each
// turn-on waits for sensed turn-off evidence, and a secondary timer forces
// the low-side turn-on when the switch-node flag never arrives.
// Assumes all inputs are synchronous to clk. TIMEOUT_CYC must exceed the
// normal switch-node dead time in cycles.
module deadtime_gate_seq #(
    parameter int TIMEOUT_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_req,
    input  logic ls_req,
    input  logic ls_off_flag,
    input  logic sw_low_flag,
    input  logic hs_off_flag,
    output logic hs_gate,
    output logic ls_gate,
    output logic timeout_pulse
);
    import gseq_pkg::*;

    seq_cmd_t   cmd;
    seq_state_t state;
    seq_state_t next_state;
    logic       expired;
    logic       in_sw_wait;

    assign in_sw_wait = (state == ST_WAIT_SW);

    gseq_req_decode u_dec (
        .hs_req (hs_req),
        .ls_req (ls_req),
        .cmd    (cmd)
    );

    gseq_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_sw_wait),
        .start   (hs_off_flag),
        .expired (expired)
    );

    gseq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd           (cmd),
        .ls_off_flag   (ls_off_flag),
        .sw_low_flag   (sw_low_flag),
        .expired       (expired),
        .state         (state),
        .next_state    (next_state),
        .timeout_pulse (timeout_pulse)
    );

    gseq_drive u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_state (next_state),
        .hs_gate    (hs_gate),
        .ls_gate    (ls_gate)
    );

    assert_hs_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> $past(ls_off_flag) && !$past(ls_gate));
    assert_ls_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> ($past(sw_low_flag) || $past(expired)) && !$past(hs_gate));
    assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> ls_gate && !$past(sw_low_flag) && $past(expired));
    assert_idle_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_req == ls_req) |=> !hs_gate && !ls_gate);
endmodule

// File: tb/sim_deadtime_gate_seq.sv
`timescale 1ns/1ps
module sim_deadtime_gate_seq;
    localparam int T = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_req = 1'b0, ls_req = 1'b0;
    logic glf = 1'b0, swf = 1'b0, vgf = 1'b0;
    logic hs_gate, ls_gate, timeout_pulse;
    int   n_chk = 0;
    int   n_fail = 0;

    always #10 clk = ~clk;

    deadtime_gate_seq #(.TIMEOUT_CYC(T)) u0 (
        .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .ls_req(ls_req),
        .ls_off_flag(glf), .sw_low_flag(swf), .hs_off_flag(vgf),
        .hs_gate(hs_gate), .ls_gate(ls_gate), .timeout_pulse(timeout_pulse)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_in(input logic h, input logic l, input logic g,
                          input logic s, input logic v);
        hs_req = h; ls_req = l; glf = g; swf = s; vgf = v;
    endtask

    task automatic go_hs_on;
        set_in(1, 0, 1, 0, 0); tick; tick;
        chk("R3 reach high side", hs_gate, 1);
    endtask

    task automatic go_ls_on;
        set_in(0, 1, 0, 1, 0); tick; tick;
        chk("R4 reach low side", ls_gate, 1);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick; tick;
        chk("R1 hs_gate in reset", hs_gate, 0);
        chk("R1 ls_gate in reset", ls_gate, 0);
        chk("R1 pulse in reset", timeout_pulse, 0);
        rst_n = 1'b1;
        tick;
        chk("R1 hs_gate after reset", hs_gate, 0);
        chk("R1 ls_gate after reset", ls_gate, 0);

        // R4 R5 R6 R7: sweep arming delay a against switch-node delay s
        for (int a = 1; a <= 6; a++) begin
            for (int s = 1; s <= 12; s++) begin
                int lat;
                bit by_to;
                go_hs_on;
                set_in(0, 1, 0, 0, 0); tick;
                chk("R4 high side dropped first", hs_gate, 0);
                chk("R4 low side waits", ls_gate, 0);
                lat = (s <= a + T) ? s : a + T;
                by_to = (a + T < s);
                for (int k = 1; k <= lat + 2; k++) begin
                    vgf = (k >= a); swf = (k >= s);
                    tick;
                    chk(by_to ? "R5 timeout turn-on" : "R4 R6 switch-node turn-on",
                        ls_gate, (k >= lat) ? 1 : 0);
                    chk("R2 high side off", hs_gate, 0);
                    chk("R7 pulse", timeout_pulse, (k == lat && by_to) ? 1 : 0);
                end
            end
        end

        // R3: sweep low-side-off flag delay g
        for (int g = 1; g <= 8; g++) begin
            go_ls_on;
            set_in(1, 0, 0, 0, 0); tick;
            chk("R3 low side dropped first", ls_gate, 0);
            chk("R3 high side waits", hs_gate, 0);
            for (int k = 1; k <= g + 2; k++) begin
                glf = (k >= g);
                tick;
                chk("R3 high-side turn-on", hs_gate, (k >= g) ? 1 : 0);
                chk("R2 low side off", ls_gate, 0);
            end
        end

        // R11: hold each gate while all flag patterns toggle
        go_hs_on;
        for (int p = 0; p < 8; p++) begin
            glf = p[0]; swf = p[1]; vgf = p[2]; tick;
            chk("R11 high side held", hs_gate, 1);
        end
        go_ls_on;
        for (int p = 0; p < 8; p++) begin
            glf = p[0]; swf = p[1]; vgf = p[2]; tick;
            chk("R11 low side held", ls_gate, 1);
            chk("R11 no pulse", timeout_pulse, 0);
        end

        // R8: idle and conflicting requests blank both gates
        go_hs_on;
        set_in(0, 0, 1, 1, 1);
        for (int k = 0; k < 3; k++) begin
            tick;
            chk("R8 idle hs", hs_gate, 0); chk("R8 idle ls", ls_gate, 0);
        end
        go_ls_on;
        set_in(1, 1, 1, 1, 1);
        for (int k = 0; k < 3; k++) begin
            tick;
            chk("R8 both hs", hs_gate, 0); chk("R8 both ls", ls_gate, 0);
        end

        // R9: high-side wait abandoned for a low-side request
        go_ls_on;
        set_in(1, 0, 0, 0, 0); tick; tick;
        chk("R9 still waiting", hs_gate, 0);
        set_in(0, 1, 1, 1, 0); tick;
        chk("R9 abandoned high side", hs_gate, 0);
        chk("R9 low side waits again", ls_gate, 0);
        tick;
        chk("R9 follows new request", ls_gate, 1);
        chk("R9 high side never rose", hs_gate, 0);

        // R10: timer cleared when leaving the wait, restarts from new arming
        go_hs_on;
        set_in(0, 1, 0, 0, 1); tick; tick; tick;
        set_in(0, 0, 0, 0, 1); tick;
        chk("R10 idle", ls_gate, 0);
        set_in(0, 1, 0, 0, 1); tick;
        for (int k = 1; k <= T + 1; k++) begin
            tick;
            chk("R10 restarted timeout", ls_gate, (k >= T + 1) ? 1 : 0);
        end
        chk("R10 pulse on restarted timeout", timeout_pulse, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule